// File: doc/BRIEF.md
# Shared-Tree Byte Parity Unit

This block holds the parity logic of one port of a dual-clock buffer whose words are 36 bits wide. Each word is four 9-bit bytes, and the top bit of each byte is that byte's parity bit. In checking, the block looks at the word on the port's input bus and drives an active-low error flag whenever any byte breaks the selected odd or even rule. In generating, it loads an outgoing word into the port's output register. The word comes either from the storage array or from the mailbox register. When generation is selected, the parity bit of each byte is recomputed from that byte's lower eight bits and written in place of the stored parity bit.

The port has one bank of four parity trees. Checking the input bus and generating parity for a mailbox read both use this bank. While a mailbox read with generation is in progress, the bank works on the mailbox word, so the error flag is forced inactive. Words read from the storage array use a dedicated generator that sits between the array output and the output register. The generate and odd/even selects therefore matter only on the clock edge that loads the word. The storage array and the mailbox registers are outside this block, and the block never writes back to them.

Top module: `byte_parity_port`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `rd_word` is cleared to all zeros.
- R2: Byte k (k = 0..3) occupies bits [9k+8:9k]. Bit 9k+8 is its parity bit and bits [9k+7:9k] are its data bits.
- R3: When `odd_sel`=1, a byte passes if its nine bits hold an odd number of ones. When `odd_sel`=0, a byte passes if they hold an even number of ones.
- R4: `perr_n` is combinational from `bus_in` and the selects. It is 0 when one or more bytes of `bus_in` fail and 1 when all four pass.
- R5: A read strobe is `cs_n`=0, `en`=1 and `wr_rd`=0. On a rising edge with a read strobe, `rd_word` loads `mail_word` when `mb_sel`=1 and `fifo_word` when `mb_sel`=0.
- R6: When `gen_sel`=1 at the loading edge, each byte's bit 9k+8 in `rd_word` becomes the parity computed from its eight data bits under `odd_sel`. The data bits are loaded unchanged.
- R7: When `gen_sel`=0 at the loading edge, the source word is loaded unchanged, including its parity bits.
- R8: `rd_word` changes only on an edge with a read strobe. `gen_sel` and `odd_sel` affect it only through their values at that edge.
- R9: While a read strobe is present with `mb_sel`=1 and `gen_sel`=1, `perr_n` is 1 whatever value `bus_in` carries.
- R10: During a mailbox read with `gen_sel`=0, `perr_n` keeps checking `bus_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low port select |
| en | input | 1 | Port transfer enable |
| wr_rd | input | 1 | 1 = write, 0 = read |
| mb_sel | input | 1 | 1 = mailbox access, 0 = storage array access |
| gen_sel | input | 1 | 1 = generate parity on reads |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| bus_in | input | 36 | Word on the port input bus |
| fifo_word | input | 36 | Word at the storage array output |
| mail_word | input | 36 | Current contents of the mailbox register being read |
| perr_n | output | 1 | Active-low parity error flag |
| rd_word | output | 36 | Output register |

## Verification
`perr_n` is combinational. The bench drives its inputs on the falling edge and reads the flag 1 ns later, in the same cycle. `rd_word` has one register stage. Each read is set up on a falling edge and the output is sampled 1 ns after the next rising edge, which is the edge that loads the word. The hold tests leave the output alone for a full cycle and change the sources and selects before checking again. Expected words are built in the bench from the byte layout and the parity rule.

// File: rtl/bp_pkg.sv
// Package: geometry of the byte-parity word and a small helper.
// Assumes each byte is DATA_BITS data bits plus one parity bit on top.
package bp_pkg;
    localparam int BYTES     = 4;
    localparam int DATA_BITS = 8;
    localparam int BYTE_W    = DATA_BITS + 1;
    localparam int WORD_W    = BYTES * BYTE_W;

    // Parity bit for a byte whose data-bit XOR is x under the chosen sense.
    function automatic logic par_bit(input logic x, input logic odd);
        return x ^ odd;
    endfunction
endpackage

// File: rtl/bp_tree_bank.sv
// Module: bank of parity trees, one per byte, each XOR-reducing the
// data bits of its byte. Assumes the byte layout in bp_pkg.
module bp_tree_bank #(
    parameter int BYTES     = bp_pkg::BYTES,
    parameter int DATA_BITS = bp_pkg::DATA_BITS,
    localparam int BYTE_W   = DATA_BITS + 1,
    localparam int WORD_W   = BYTES * BYTE_W
) (
    input  logic [WORD_W-1:0] word,
    output logic [BYTES-1:0]  xor_data
);
    for (genvar b = 0; b < BYTES; b++) begin : g_tree
        // Reduce the data bits of byte b.
        always_comb xor_data[b] = ^word[b*BYTE_W +: DATA_BITS];
    end
endmodule

// File: rtl/bp_check.sv
// Module: error-flag logic. It combines the tree results with each
// byte's parity bit. Assumes xor_data was computed from the same word.
// The flag is forced inactive while the trees are lent out.
module bp_check #(
    parameter int BYTES     = bp_pkg::BYTES,
    parameter int DATA_BITS = bp_pkg::DATA_BITS,
    localparam int BYTE_W   = DATA_BITS + 1,
    localparam int WORD_W   = BYTES * BYTE_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic [BYTES-1:0]  xor_data,
    input  logic              odd_sel,
    input  logic              trees_busy,
    output logic              perr_n
);
    logic [BYTES-1:0] byte_bad;

    for (genvar b = 0; b < BYTES; b++) begin : g_bad
        // Byte fails when its nine-bit XOR differs from the selected sense.
        always_comb byte_bad[b] = xor_data[b] ^ word[b*BYTE_W + DATA_BITS] ^ odd_sel;
    end

    // Flag low on any failing byte, held high while trees are borrowed.
    always_comb perr_n = trees_busy | ~(|byte_bad);
endmodule

// File: rtl/bp_gen.sv
// Module: parity substitution. It overwrites each byte's top bit with
// parity derived from the given tree results. Assumes xor_data belongs
// to word.
module bp_gen #(
    parameter int BYTES     = bp_pkg::BYTES,
    parameter int DATA_BITS = bp_pkg::DATA_BITS,
    localparam int BYTE_W   = DATA_BITS + 1,
    localparam int WORD_W   = BYTES * BYTE_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic [BYTES-1:0]  xor_data,
    input  logic              odd_sel,
    output logic [WORD_W-1:0] gen_word
);
    for (genvar b = 0; b < BYTES; b++) begin : g_sub
        // Keep data bits, replace parity bit.
        always_comb begin
            gen_word[b*BYTE_W +: DATA_BITS]  = word[b*BYTE_W +: DATA_BITS];
            gen_word[b*BYTE_W + DATA_BITS]   = bp_pkg::par_bit(xor_data[b], odd_sel);
        end
    end
endmodule

// File: rtl/byte_parity_port.sv
// Module: one port's parity unit. It checks the input bus, generates
// parity on reads and holds the output register. Assumes the selects
// are stable around the clock edge that loads a word.
module byte_parity_port #(
    parameter int BYTES     = bp_pkg::BYTES,
    parameter int DATA_BITS = bp_pkg::DATA_BITS,
    localparam int BYTE_W   = DATA_BITS + 1,
    localparam int WORD_W   = BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              en,
    input  logic              wr_rd,
    input  logic              mb_sel,
    input  logic              gen_sel,
    input  logic              odd_sel,
    input  logic [WORD_W-1:0] bus_in,
    input  logic [WORD_W-1:0] fifo_word,
    input  logic [WORD_W-1:0] mail_word,
    output logic              perr_n,
    output logic [WORD_W-1:0] rd_word
);
    logic              rd_stb;
    logic              mail_gen;
    logic [WORD_W-1:0] shared_in;
    logic [BYTES-1:0]  shared_xor;
    logic [BYTES-1:0]  fifo_xor;
    logic [WORD_W-1:0] mail_gen_word;
    logic [WORD_W-1:0] fifo_gen_word;
    logic [WORD_W-1:0] next_word;

    // Decode the read strobe and the mailbox-generation borrow.
    always_comb begin
        rd_stb   = ~cs_n & en & ~wr_rd;
        mail_gen = rd_stb & mb_sel & gen_sel;
    end

    // Shared trees see the mailbox word while borrowed, else the bus.
    always_comb shared_in = mail_gen ? mail_word : bus_in;

    bp_tree_bank #(.BYTES(BYTES), .DATA_BITS(DATA_BITS)) u_shared_trees (
        .word(shared_in), .xor_data(shared_xor));

    bp_check #(.BYTES(BYTES), .DATA_BITS(DATA_BITS)) u_check (
        .word(bus_in), .xor_data(shared_xor), .odd_sel(odd_sel),
        .trees_busy(mail_gen), .perr_n(perr_n));

    bp_gen #(.BYTES(BYTES), .DATA_BITS(DATA_BITS)) u_mail_gen (
        .word(mail_word), .xor_data(shared_xor), .odd_sel(odd_sel),
        .gen_word(mail_gen_word));

    bp_tree_bank #(.BYTES(BYTES), .DATA_BITS(DATA_BITS)) u_fifo_trees (
        .word(fifo_word), .xor_data(fifo_xor));

    bp_gen #(.BYTES(BYTES), .DATA_BITS(DATA_BITS)) u_fifo_gen (
        .word(fifo_word), .xor_data(fifo_xor), .odd_sel(odd_sel),
        .gen_word(fifo_gen_word));

    // Pick the word to load from source and generate select.
    always_comb begin
        if (mb_sel) next_word = gen_sel ? mail_gen_word : mail_word;
        else        next_word = gen_sel ? fifo_gen_word : fifo_word;
    end

    // Output register: cleared in reset, loaded on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_word <= '0;
        else if (rd_stb) rd_word <= next_word;
    end

    // R1: reset clears the output register.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> rd_word == '0);

    // R9: flag held inactive during a mailbox read with generation.
    assert_flag_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && mb_sel && gen_sel) |-> perr_n);

    // R8: no strobe, no change.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_word));

    // R7: storage read without generation loads the word unchanged.
    assert_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !mb_sel && !gen_sel) |=> rd_word == $past(fifo_word));

    for (genvar b = 0; b < BYTES; b++) begin : g_chk
        // R6: every byte loaded with generation meets the sampled sense.
        assert_gen_sense_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_stb && gen_sel) |=> (^rd_word[b*BYTE_W +: BYTE_W]) == $past(odd_sel));
    end
endmodule

// File: tb/byte_parity_port_test.sv
// Directed bench for byte_parity_port. Each scenario is a task that
// checks its own results.
module byte_parity_port_test;
    localparam int W = 36;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          cs_n = 1, en = 0, wr_rd = 1, mb_sel = 0, gen_sel = 0, odd_sel = 1;
    logic [W-1:0]  bus_in = '0, fifo_word = '0, mail_word = '0;
    logic          perr_n;
    logic [W-1:0]  rd_word;
    int            checks = 0;
    int            fails  = 0;
    bit            done   = 0;

    always #4 clk = ~clk;

    byte_parity_port uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .en(en), .wr_rd(wr_rd),
        .mb_sel(mb_sel), .gen_sel(gen_sel), .odd_sel(odd_sel),
        .bus_in(bus_in), .fifo_word(fifo_word), .mail_word(mail_word),
        .perr_n(perr_n), .rd_word(rd_word));

    // Expected word with parity bits regenerated (R2/R3 layout and rule).
    function automatic logic [W-1:0] exp_gen(input logic [W-1:0] w, input logic odd);
        logic [W-1:0] r = w;
        for (int b = 0; b < 4; b++) begin
            int ones = 0;
            for (int i = 0; i < 8; i++) ones += int'(w[b*9+i]);
            r[b*9+8] = odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
        end
        return r;
    endfunction

    // Expected flag: 0 if any byte breaks the rule.
    function automatic logic exp_flag(input logic [W-1:0] w, input logic odd);
        logic ok = 1;
        for (int b = 0; b < 4; b++) begin
            int ones = 0;
            for (int i = 0; i < 9; i++) ones += int'(w[b*9+i]);
            if (odd ? ((ones % 2) == 0) : ((ones % 2) == 1)) ok = 0;
        end
        return ok;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        cs_n = 1; en = 0; wr_rd = 1;
    endtask

    task automatic read_strobe(input logic mb, input logic gen, input logic odd);
        cs_n = 0; en = 1; wr_rd = 0; mb_sel = mb; gen_sel = gen; odd_sel = odd;
    endtask

    task automatic t_reset();
        fifo_word = 36'h9_1234_5678;
        @(negedge clk); read_strobe(0, 0, 1); rst_n = 0;
        @(posedge clk); #1;
        chk("R1 reset clears rd_word", rd_word, '0);
        @(negedge clk); idle(); rst_n = 1;
    endtask

    task automatic t_check();
        logic [W-1:0] w;
        @(negedge clk); idle(); odd_sel = 1;
        // Bytes 0x001, 0x003 with bit8, etc. chosen to be all-odd.
        w = exp_gen(36'h0_0000_0000, 1) | 36'h0_0201_0603;
        w = exp_gen(w, 1);
        bus_in = w; #1;
        chk("R4 all bytes pass odd", perr_n, exp_flag(w, 1));
        chk("R3 odd rule good word", perr_n, 1'b1);
        odd_sel = 0; #1;
        chk("R3 even rule same word fails", perr_n, 1'b0);
        odd_sel = 1; bus_in = w ^ (36'h1 << 20); #1;
        chk("R2 R4 one bad byte (byte 2)", perr_n, 1'b0);
        bus_in = w ^ (36'h1 << 35); #1;
        chk("R2 R4 parity bit of byte 3 flipped", perr_n, 1'b0);
        odd_sel = 0; bus_in = exp_gen(36'h5_A5C3_0F11, 0); #1;
        chk("R3 even rule good word", perr_n, 1'b1);
    endtask

    task automatic t_fifo_gen();
        fifo_word = 36'hF_0123_ABCD;
        @(negedge clk); read_strobe(0, 1, 1);
        @(posedge clk); #1;
        chk("R5 R6 storage read odd generation", rd_word, exp_gen(fifo_word, 1));
        @(negedge clk); read_strobe(0, 1, 0);
        @(posedge clk); #1;
        chk("R6 storage read even generation", rd_word, exp_gen(fifo_word, 0));
    endtask

    task automatic t_passthru();
        fifo_word = 36'hA_5555_AAAA;
        @(negedge clk); read_strobe(0, 0, 1);
        @(posedge clk); #1;
        chk("R7 no generation loads unchanged", rd_word, 36'hA_5555_AAAA);
    endtask

    task automatic t_hold();
        logic [W-1:0] held;
        fifo_word = 36'h3_C3C3_1234;
        @(negedge clk); read_strobe(0, 1, 1);
        @(posedge clk); #1;
        held = exp_gen(36'h3_C3C3_1234, 1);
        chk("R6 load before hold", rd_word, held);
        @(negedge clk); wr_rd = 1; odd_sel = 0; gen_sel = 0; fifo_word = 36'h0_FFFF_0000;
        @(posedge clk); #1;
        chk("R8 write strobe holds output", rd_word, held);
        @(negedge clk); wr_rd = 0; cs_n = 1;
        @(posedge clk); #1;
        chk("R8 deselected holds output", rd_word, held);
        @(negedge clk); cs_n = 0; en = 0;
        @(posedge clk); #1;
        chk("R8 disabled holds output", rd_word, held);
        @(negedge clk); idle();
    endtask

    task automatic t_mail();
        logic [W-1:0] bad;
        bad = exp_gen(36'h1_2345_6789, 1) ^ 36'h1;
        mail_word = 36'h7_89AB_CDEF;
        @(negedge clk); bus_in = bad; read_strobe(1, 1, 1); #1;
        chk("R9 flag held high during mailbox generation", perr_n, 1'b1);
        @(posedge clk); #1;
        chk("R5 R6 mailbox read with generation", rd_word, exp_gen(36'h7_89AB_CDEF, 1));
        @(negedge clk); read_strobe(1, 0, 1); #1;
        chk("R10 mailbox read without generation still checks", perr_n, 1'b0);
        @(posedge clk); #1;
        chk("R5 R7 mailbox read unchanged", rd_word, 36'h7_89AB_CDEF);
        @(negedge clk); idle(); #1;
        chk("R4 flag returns after borrow", perr_n, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_check();
        t_fifo_gen();
        t_passthru();
        t_hold();
        t_mail();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule